// File: doc/BRIEF.md
# Hierarchical 64-Request Priority Encoder

This block takes 64 request lines and returns the number of the highest-numbered request that is active, together with a flag that says whether any request is active at all. Request lines are active-low: a line held at 0 is requesting. The index and the flag are active-high. The block is purely combinational, so a change on the request lines reaches the outputs in the same cycle.

Priority is resolved in two levels. The requests form eight groups of eight, and each group has its own 8-lane encoder slice. The slices are chained through their enable ports from the top group down. A slice is enabled only when every slice above it has found no request, so exactly one group can win. A ninth slice of the same kind receives the eight group-hit flags. It produces the group number, which forms the upper three index bits. The lower three bits come from merging the code outputs of the eight group slices. Every slice that does not win drives an idle code, so only the winner shows through the merge.

Top module: `prio_enc64`

## Requirements
- R1: `valid` is 1 exactly when at least one bit of `req_n` is 0. A 0 on `req_n[i]` means request i is active, and a 1 means it is inactive.
- R2: While `valid` is 1, `index` equals the largest i for which `req_n[i]` is 0.
- R3: When every bit of `req_n` is 1, `index` is 0 and `valid` is 0.
- R4: Requests in a higher group (group g holds requests 8g to 8g+7) win over any requests in lower groups. When that happens, `index[5:3]` equals the winning group number.
- R5: Within the winning group, `index[2:0]` is the position of the highest active request inside that group. Other requests active in the same group do not change it.
- R6: When all 64 requests are active, `index` is 63 and `valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | 64 | Request lines, active-low; bit i is request i |
| index | output | 6 | Number of the highest active request, active-high |
| valid | output | 1 | High when any request is active |

## Verification
The assertions assume that `req_n` is fully driven with 0 or 1 on every bit. They also assume their checks are evaluated after the combinational network has settled. The bench applies each request pattern at a clock edge and reads the outputs half a period later, so every pattern has settled and is two-valued when it is read. The patterns cover:
- a single request on each of the 64 lines;
- pairs of requests that straddle groups;
- pairs of requests inside one group;
- every request active, and no request active;
- pseudo-random patterns from a shift register.

Each pattern is compared with a reference loop written in the bench.

// File: rtl/prio_pkg.sv
// Shared sizing for the hierarchical priority encoder.
// Assumes the group count equals the slice lane count, so that one
// slice can also encode the group-hit flags.
package prio_pkg;
    localparam int LANES = 8;
    localparam int CODE_W = $clog2(LANES);
    localparam int REQ_CNT = LANES * LANES;
    localparam int IDX_W = 2 * CODE_W;
endpackage

// File: rtl/prio_slice.sv
// Cascadable priority encoder slice. All ports are active-low.
// When disabled, it drives an idle code (all ones) and raises no flags.
// When enabled, it either reports the highest active lane, or passes
// the enable downward through en_out_n if no lane is active.
module prio_slice #(
    parameter int LANES = 8,
    parameter int CODE_W = $clog2(LANES)
) (
    input  logic              en_n,
    input  logic [LANES-1:0]  req_n,
    output logic [CODE_W-1:0] code_n,
    output logic              hit_n,
    output logic              en_out_n
);
    logic              any_req;
    logic [CODE_W-1:0] top_pos;

    // Find the highest active lane; later (higher) lanes overwrite earlier ones.
    always_comb begin
        any_req = 1'b0;
        top_pos = '0;
        for (int i = 0; i < LANES; i++) begin
            if (!req_n[i]) begin
                any_req = 1'b1;
                top_pos = CODE_W'(i);
            end
        end
    end

    // Drive the code, group-hit and enable-out from enable and the search result.
    always_comb begin
        code_n   = '1;
        hit_n    = 1'b1;
        en_out_n = 1'b1;
        if (!en_n) begin
            if (any_req) begin
                code_n = ~top_pos;
                hit_n  = 1'b0;
            end else begin
                en_out_n = 1'b0;
            end
        end
    end
endmodule

// File: rtl/code_merge.sv
// Merges active-low codes from several slices into one active-high code.
// Assumes every slice except at most one drives the idle code (all ones).
module code_merge #(
    parameter int SRC = 8,
    parameter int CODE_W = 3
) (
    input  logic [SRC-1:0][CODE_W-1:0] codes_n,
    output logic [CODE_W-1:0]          code
);
    logic [CODE_W-1:0] acc;

    // Bitwise AND of the active-low codes, then invert to active-high.
    always_comb begin
        acc = '1;
        for (int g = 0; g < SRC; g++) begin
            acc &= codes_n[g];
        end
        code = ~acc;
    end
endmodule

// File: rtl/prio_enc64.sv
// 64-request priority encoder built from nine cascadable slices.
// The group slices are chained from the top group down by enable. A ninth
// slice encodes the group-hit flags into the upper index bits. The lower
// bits are merged from the group slices' codes.
// Assumes req_n is active-low. The outputs are combinational.
module prio_enc64
    import prio_pkg::*;
(
    input  logic [REQ_CNT-1:0] req_n,
    output logic [IDX_W-1:0]   index,
    output logic               valid
);
    logic [LANES-1:0]             en_n;
    logic [LANES-1:0]             en_out_n;
    logic [LANES-1:0]             grp_n;
    logic [LANES-1:0][CODE_W-1:0] low_codes_n;
    logic [CODE_W-1:0]            grp_code_n;
    logic                         top_hit_n;
    logic                         top_en_out_n;
    logic [CODE_W-1:0]            low_code;

    // One slice per group; the top group is always enabled.
    for (genvar g = 0; g < LANES; g++) begin : g_grp
        if (g == LANES - 1) begin : g_top
            assign en_n[g] = 1'b0;
        end else begin : g_chain
            assign en_n[g] = en_out_n[g+1];
        end
        prio_slice #(.LANES(LANES), .CODE_W(CODE_W)) u_slice (
            .en_n     (en_n[g]),
            .req_n    (req_n[g*LANES +: LANES]),
            .code_n   (low_codes_n[g]),
            .hit_n    (grp_n[g]),
            .en_out_n (en_out_n[g])
        );
    end

    // The ninth slice turns the group-hit flags into the group number.
    prio_slice #(.LANES(LANES), .CODE_W(CODE_W)) u_grp_slice (
        .en_n     (1'b0),
        .req_n    (grp_n),
        .code_n   (grp_code_n),
        .hit_n    (top_hit_n),
        .en_out_n (top_en_out_n)
    );

    code_merge #(.SRC(LANES), .CODE_W(CODE_W)) u_merge (
        .codes_n (low_codes_n),
        .code    (low_code)
    );

    // Assemble the active-high outputs.
    assign index = {~grp_code_n, low_code};
    assign valid = ~top_hit_n;
endmodule

// File: rtl/prio_enc64_chk.sv
// Property checker for prio_enc64, attached with bind.
// Assumes its inputs are two-valued and have settled when evaluated.
module prio_enc64_chk
    import prio_pkg::*;
(
    input logic [REQ_CNT-1:0] req_n,
    input logic [IDX_W-1:0]   index,
    input logic               valid,
    input logic [LANES-1:0]   grp_n
);
    logic [REQ_CNT-1:0] above;

    // Shift the active-high requests so that bit 0 is the reported winner.
    assign above = (~req_n) >> index;

    // Check the output relations whenever the inputs change.
    always_comb begin
        p_valid_any_r1: assert (valid == (req_n != '1))
            else $error("valid does not match any-request");
        p_win_top_r2: assert (!valid || above == REQ_CNT'(1))
            else $error("index is not the highest active request");
        p_idle_zero_r3: assert (valid || index == '0)
            else $error("index nonzero while idle");
        p_one_group_r4: assert ($onehot0(~grp_n))
            else $error("more than one group slice won");
        p_group_bits_r4: assert (!valid || !grp_n[index[IDX_W-1:CODE_W]])
            else $error("upper index bits do not name the winning group");
    end
endmodule

bind prio_enc64 prio_enc64_chk u_chk (
    .req_n (req_n),
    .index (index),
    .valid (valid),
    .grp_n (grp_n)
);

// File: tb/tb_prio_enc64.sv
module tb_prio_enc64;
    typedef struct {
        logic [5:0] idx;
        logic       vld;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] req_n = '1;
    logic [5:0]  index;
    logic        valid;
    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    prio_enc64 dut (.req_n(req_n), .index(index), .valid(valid));

    always #2.5 clk = ~clk;

    // Drive one pattern at a clock edge and push the reference result.
    task automatic drive(input logic [63:0] pat, input string tag);
        exp_t e;
        e.idx = '0;
        e.vld = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (!pat[i]) begin
                e.idx = 6'(i);
                e.vld = 1'b1;
            end
        end
        e.tag = tag;
        @(posedge clk);
        req_n <= pat;
        sb.push_back(e);
    endtask

    // Monitor: pop and compare half a period after each pattern is applied.
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (valid !== e.vld) begin
                errors++;
                $display("FAIL R1 (%s) valid actual %0b expected %0b", e.tag, valid, e.vld);
            end
            checks++;
            if (index !== e.idx) begin
                errors++;
                $display("FAIL %s index actual %0d expected %0d", e.tag, index, e.idx);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] lfsr;
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;
        // Reset state with no requests (R3).
        drive('1, "R3");
        // Single request on each line (R2).
        for (int i = 0; i < 64; i++) drive(~(64'd1 << i), "R2");
        // Pairs in different groups: the higher group wins (R4).
        for (int a = 0; a < 8; a++)
            for (int b = a + 1; b < 8; b++)
                drive(~((64'd1 << (a*8 + (b % 8))) | (64'd1 << (b*8 + (a % 8)))), "R4");
        // Pairs inside one group: the higher position wins (R5).
        for (int g = 0; g < 8; g++)
            for (int p = 0; p < 7; p++)
                drive(~((64'd1 << (g*8 + p)) | (64'd1 << (g*8 + 7 - (p % 3)))), "R5");
        // Everything active (R6), then nothing again (R3).
        drive('0, "R6");
        drive('1, "R3");
        // Pseudo-random patterns (R1, R2).
        lfsr = 64'hACE1_2468_1357_9BDF;
        for (int k = 0; k < 200; k++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            drive(lfsr | (k[0] ? 64'hFFFF_0000_FFFF_0000 : 64'h0), "R2");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule